// File: doc/BRIEF.md
# Three-C Cache Miss Classifier

This block sits beside a small set-associative cache and watches the block addresses presented to it. For every access it decides whether the block was resident, and when it was not, it decides why: first touch of the block, not enough total room, or an unlucky set mapping. To make that decision it keeps three pieces of state. The first is its own tag model of the real cache. The second is a fully associative shadow tag store with the same total number of blocks. The third is a one-bit-per-address record of which blocks have ever been referenced.

Each accepted request produces a registered two-bit class code with a valid strobe one cycle later. Four saturating counters, one per class, are updated on the same clock edge. A synchronous clear returns all tag state, the first-touch record and the counters to empty, so a new measurement window can begin without a reset. The data arrays, refills, write policy, coherence and hierarchy effects are not part of the block.

Top module: `miss_classifier`

## Requirements
- R1: A cycle with `req_valid_i` high and `clear_i` low produces `cls_valid_o` high on the next cycle, with `cls_o` encoded 2'b00 hit, 2'b01 compulsory, 2'b10 capacity, 2'b11 conflict. In all other cycles `cls_valid_o` is low on the next cycle.
- R2: A request whose block address has not been referenced since reset or the last clear, and that misses the real cache, is classed compulsory, whatever the shadow store holds.
- R3: The real cache has CAPACITY/WAYS sets (default 4 sets of 4 ways). It takes the set index from the low address bits and the tag from the rest. A request whose block is resident in its set is classed hit.
- R4: A real-cache miss on a previously referenced block that is resident in the shadow store is classed conflict.
- R5: A real-cache miss on a previously referenced block that is also absent from the shadow store is classed capacity.
- R6: The real model and the shadow store (CAPACITY blocks, full address compare) both use true LRU replacement. They are updated on every accepted request, hits included, and fill empty entries before evicting.
- R7: On the edge that registers a class, only the counter of that class changes, and it rises by exactly one. Without an accepted request, no counter changes.
- R8: Each counter saturates at 2^CNT_W-1 and holds there.
- R9: `clear_i` empties both tag stores and the first-touch record and zeroes all counters on the next edge. A request in the same cycle is dropped and yields no class.
- R10: The compulsory counter equals the number of distinct block addresses referenced since reset or the last clear, below saturation.
- R11: While `rst_ni` is low, `cls_valid_o` is low and all counters read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clear_i | input | 1 | Synchronous clear of all state and counters |
| req_valid_i | input | 1 | Request strobe |
| req_addr_i | input | ADDR_W | Block address of the access |
| cls_valid_o | output | 1 | Class result valid, one cycle after the request |
| cls_o | output | 2 | Class code: 00 hit, 01 compulsory, 10 capacity, 11 conflict |
| cnt_hit_o | output | CNT_W | Saturating hit count |
| cnt_comp_o | output | CNT_W | Saturating compulsory miss count |
| cnt_cap_o | output | CNT_W | Saturating capacity miss count |
| cnt_conf_o | output | CNT_W | Saturating conflict miss count |

## Verification
The checker watches several properties on every cycle: the one-cycle relation between a request and its strobe, counters that move by one in the class just reported and hold otherwise, saturation, the effect of clear, and the bound on the compulsory count. Whether a given address is a hit or a conflict or capacity miss depends on LRU history in two stores, so only the bench can show it. It compares every cycle against a recency-queue model. Targeted streams cover set thrashing, overflow of the working set, hits that refresh LRU order, and first touches after a clear.

// File: rtl/miss_cls_pkg.sv
package miss_cls_pkg;
  typedef enum logic [1:0] {
    CLS_HIT        = 2'b00,
    CLS_COMPULSORY = 2'b01,
    CLS_CAPACITY   = 2'b10,
    CLS_CONFLICT   = 2'b11
  } miss_cls_e;
endpackage

// File: rtl/lru_tag_store.sv
// Fully associative tag store with true LRU (age permutation) replacement.
module lru_tag_store #(
  parameter int ENTRIES = 4,
  parameter int KEY_W   = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             access_i,
  input  logic [KEY_W-1:0] key_i,
  output logic             hit_o
);
  localparam int AGE_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [ENTRIES-1:0] vld_q;
  logic [KEY_W-1:0]   key_q [ENTRIES];
  logic [AGE_W-1:0]   age_q [ENTRIES];
  logic [ENTRIES-1:0] hit_vec;
  logic [AGE_W-1:0]   tgt;
  logic [AGE_W-1:0]   ref_age;
  logic               found;

  for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
    assign hit_vec[i] = vld_q[i] && (key_q[i] == key_i);
  end
  assign hit_o = |hit_vec;

  // target: hit way, else first empty way, else oldest way
  always_comb begin
    tgt   = '0;
    found = 1'b0;
    for (int i = 0; i < ENTRIES; i++)
      if (!found && hit_vec[i]) begin
        tgt   = AGE_W'(i);
        found = 1'b1;
      end
    for (int i = 0; i < ENTRIES; i++)
      if (!found && !vld_q[i]) begin
        tgt   = AGE_W'(i);
        found = 1'b1;
      end
    for (int i = 0; i < ENTRIES; i++)
      if (!found && (age_q[i] == AGE_W'(ENTRIES - 1))) begin
        tgt   = AGE_W'(i);
        found = 1'b1;
      end
  end

  assign ref_age = age_q[tgt];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < ENTRIES; i++) begin
        vld_q[i] <= 1'b0;
        key_q[i] <= '0;
        age_q[i] <= AGE_W'(i);
      end
    end else if (clear_i) begin
      for (int i = 0; i < ENTRIES; i++) begin
        vld_q[i] <= 1'b0;
        key_q[i] <= '0;
        age_q[i] <= AGE_W'(i);
      end
    end else if (access_i) begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (AGE_W'(i) == tgt) begin
          vld_q[i] <= 1'b1;
          key_q[i] <= key_i;
          age_q[i] <= '0;
        end else if (age_q[i] < ref_age) begin
          age_q[i] <= age_q[i] + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/set_assoc_model.sv
// Tag model of the real cache: one LRU store per set.
module set_assoc_model #(
  parameter int ADDR_W = 8,
  parameter int SETS   = 4,
  parameter int WAYS   = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              access_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hit_o
);
  localparam int SET_W = (SETS > 1) ? $clog2(SETS) : 1;
  localparam int TAG_W = ADDR_W - SET_W;

  logic [SET_W-1:0] set_idx;
  logic [TAG_W-1:0] tag;
  logic [SETS-1:0]  set_hit;

  assign set_idx = addr_i[SET_W-1:0];
  assign tag     = addr_i[ADDR_W-1:SET_W];

  for (genvar s = 0; s < SETS; s++) begin : g_set
    lru_tag_store #(
      .ENTRIES(WAYS),
      .KEY_W  (TAG_W)
    ) u_set (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .clear_i (clear_i),
      .access_i(access_i && (set_idx == SET_W'(s))),
      .key_i   (tag),
      .hit_o   (set_hit[s])
    );
  end

  assign hit_o = set_hit[set_idx];
endmodule

// File: rtl/first_touch_record.sv
module first_touch_record #(
  parameter int ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              access_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              seen_o
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DEPTH-1:0] seen_q;

  assign seen_o = seen_q[addr_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       seen_q <= '0;
    else if (clear_i)  seen_q <= '0;
    else if (access_i) seen_q[addr_i] <= 1'b1;
  end
endmodule

// File: rtl/class_counters.sv
module class_counters #(
  parameter int CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             inc_vld_i,
  input  logic [1:0]       cls_i,
  output logic [CNT_W-1:0] cnt_hit_o,
  output logic [CNT_W-1:0] cnt_comp_o,
  output logic [CNT_W-1:0] cnt_cap_o,
  output logic [CNT_W-1:0] cnt_conf_o
);
  localparam int N_CLS = 4;

  logic [CNT_W-1:0] cnt_q [N_CLS];

  for (genvar k = 0; k < N_CLS; k++) begin : g_cnt
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      cnt_q[k] <= '0;
      else if (clear_i) cnt_q[k] <= '0;
      else if (inc_vld_i && (cls_i == 2'(k)) && (cnt_q[k] != '1))
        cnt_q[k] <= cnt_q[k] + 1'b1;
    end
  end

  assign cnt_hit_o  = cnt_q[0];
  assign cnt_comp_o = cnt_q[1];
  assign cnt_cap_o  = cnt_q[2];
  assign cnt_conf_o = cnt_q[3];
endmodule

// File: rtl/miss_classifier.sv
module miss_classifier
  import miss_cls_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int CAPACITY = 16,
  parameter int WAYS     = 4,
  parameter int CNT_W    = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              req_valid_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  output logic              cls_valid_o,
  output logic [1:0]        cls_o,
  output logic [CNT_W-1:0]  cnt_hit_o,
  output logic [CNT_W-1:0]  cnt_comp_o,
  output logic [CNT_W-1:0]  cnt_cap_o,
  output logic [CNT_W-1:0]  cnt_conf_o
);
  localparam int SETS = CAPACITY / WAYS;

  logic      access;
  logic      real_hit;
  logic      shadow_hit;
  logic      seen;
  miss_cls_e cls_d, cls_q;
  logic      vld_q;

  assign access = req_valid_i && !clear_i;

  set_assoc_model #(
    .ADDR_W(ADDR_W),
    .SETS  (SETS),
    .WAYS  (WAYS)
  ) u_real (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (clear_i),
    .access_i(access),
    .addr_i  (req_addr_i),
    .hit_o   (real_hit)
  );

  lru_tag_store #(
    .ENTRIES(CAPACITY),
    .KEY_W  (ADDR_W)
  ) u_shadow (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (clear_i),
    .access_i(access),
    .key_i   (req_addr_i),
    .hit_o   (shadow_hit)
  );

  first_touch_record #(
    .ADDR_W(ADDR_W)
  ) u_seen (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (clear_i),
    .access_i(access),
    .addr_i  (req_addr_i),
    .seen_o  (seen)
  );

  // first-touch test outranks the shadow lookup
  always_comb begin
    if (real_hit)        cls_d = CLS_HIT;
    else if (!seen)      cls_d = CLS_COMPULSORY;
    else if (shadow_hit) cls_d = CLS_CONFLICT;
    else                 cls_d = CLS_CAPACITY;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= 1'b0;
      cls_q <= CLS_HIT;
    end else begin
      vld_q <= access;
      if (access) cls_q <= cls_d;
    end
  end

  assign cls_valid_o = vld_q;
  assign cls_o       = cls_q;

  class_counters #(
    .CNT_W(CNT_W)
  ) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clear_i   (clear_i),
    .inc_vld_i (access),
    .cls_i     (cls_d),
    .cnt_hit_o (cnt_hit_o),
    .cnt_comp_o(cnt_comp_o),
    .cnt_cap_o (cnt_cap_o),
    .cnt_conf_o(cnt_conf_o)
  );
endmodule

// File: rtl/miss_classifier_chk.sv
module miss_classifier_chk #(
  parameter int ADDR_W = 8,
  parameter int CNT_W  = 32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             clear_i,
  input logic             req_valid_i,
  input logic             cls_valid_o,
  input logic [1:0]       cls_o,
  input logic [CNT_W-1:0] cnt_hit_o,
  input logic [CNT_W-1:0] cnt_comp_o,
  input logic [CNT_W-1:0] cnt_cap_o,
  input logic [CNT_W-1:0] cnt_conf_o
);
  localparam logic [CNT_W-1:0] CMAX = '1;
  localparam longint unsigned N_BLK = 64'd1 << ADDR_W;

  logic armed_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) armed_q <= 1'b0;
    else         armed_q <= 1'b1;
  end

  p_strobe_follows_req_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_q |-> (cls_valid_o == $past(req_valid_i && !clear_i)));

  p_hit_step_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cls_valid_o && cls_o == 2'b00 && $past(cnt_hit_o) != CMAX) |->
      (cnt_hit_o == $past(cnt_hit_o) + 1'b1));
  p_comp_step_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cls_valid_o && cls_o == 2'b01 && $past(cnt_comp_o) != CMAX) |->
      (cnt_comp_o == $past(cnt_comp_o) + 1'b1));
  p_cap_step_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cls_valid_o && cls_o == 2'b10 && $past(cnt_cap_o) != CMAX) |->
      (cnt_cap_o == $past(cnt_cap_o) + 1'b1));
  p_conf_step_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cls_valid_o && cls_o == 2'b11 && $past(cnt_conf_o) != CMAX) |->
      (cnt_conf_o == $past(cnt_conf_o) + 1'b1));

  p_one_counter_moves_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_q && !$past(clear_i)) |->
      ($countones({cnt_hit_o != $past(cnt_hit_o), cnt_comp_o != $past(cnt_comp_o),
                   cnt_cap_o != $past(cnt_cap_o), cnt_conf_o != $past(cnt_conf_o)}) <= 1));

  p_idle_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_q && !cls_valid_o && !$past(clear_i)) |->
      ($stable(cnt_hit_o) && $stable(cnt_comp_o) && $stable(cnt_cap_o) && $stable(cnt_conf_o)));

  p_saturate_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_q && $past(cnt_hit_o) == CMAX && !$past(clear_i)) |-> (cnt_hit_o == CMAX));

  p_clear_empties_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_q && $past(clear_i)) |->
      (!cls_valid_o && cnt_hit_o == '0 && cnt_comp_o == '0 && cnt_cap_o == '0 && cnt_conf_o == '0));

  p_comp_bound_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    64'(cnt_comp_o) <= N_BLK);

  always_comb begin
    if (!rst_ni) begin
      a_reset_quiet_r11: assert (!cls_valid_o && cnt_hit_o == '0 && cnt_comp_o == '0);
    end
  end
endmodule

bind miss_classifier miss_classifier_chk #(
  .ADDR_W(ADDR_W),
  .CNT_W (CNT_W)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .clear_i    (clear_i),
  .req_valid_i(req_valid_i),
  .cls_valid_o(cls_valid_o),
  .cls_o      (cls_o),
  .cnt_hit_o  (cnt_hit_o),
  .cnt_comp_o (cnt_comp_o),
  .cnt_cap_o  (cnt_cap_o),
  .cnt_conf_o (cnt_conf_o)
);

// File: tb/miss_classifier_tb_top.sv
module miss_classifier_tb_top;
  localparam int ADDR_W = 8;
  localparam int CAP    = 16;
  localparam int WAYS   = 4;
  localparam int SETS   = CAP / WAYS;
  localparam int CNT_W  = 4;
  localparam int CMAX   = (1 << CNT_W) - 1;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              clear_i = 1'b0;
  logic              req_valid_i = 1'b0;
  logic [ADDR_W-1:0] req_addr_i = '0;
  logic              cls_valid_o;
  logic [1:0]        cls_o;
  logic [CNT_W-1:0]  cnt_hit_o, cnt_comp_o, cnt_cap_o, cnt_conf_o;

  always #4 clk_i = ~clk_i;

  miss_classifier #(
    .ADDR_W(ADDR_W), .CAPACITY(CAP), .WAYS(WAYS), .CNT_W(CNT_W)
  ) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .clear_i(clear_i),
    .req_valid_i(req_valid_i), .req_addr_i(req_addr_i),
    .cls_valid_o(cls_valid_o), .cls_o(cls_o),
    .cnt_hit_o(cnt_hit_o), .cnt_comp_o(cnt_comp_o),
    .cnt_cap_o(cnt_cap_o), .cnt_conf_o(cnt_conf_o)
  );

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  // behavioural model: recency queues, front = most recent
  int real_q[$];
  int shad_q[$];
  bit seen[256];
  int exp_cnt[4];
  int distinct = 0;

  function automatic string cls_req(int c);
    case (c)
      0: return "R3";
      1: return "R2";
      2: return "R5";
      default: return "R4";
    endcase
  endfunction

  function automatic int find_in(const ref int q[$], int v);
    foreach (q[i]) if (q[i] == v) return i;
    return -1;
  endfunction

  task automatic model_clear();
    real_q.delete();
    shad_q.delete();
    foreach (seen[i]) seen[i] = 1'b0;
    foreach (exp_cnt[i]) exp_cnt[i] = 0;
    distinct = 0;
  endtask

  function automatic int model_access(int a);
    int ri, si, c, n_in_set, last;
    ri = find_in(real_q, a);
    si = find_in(shad_q, a);
    if (ri >= 0)      c = 0;
    else if (!seen[a]) c = 1;
    else if (si >= 0) c = 3;
    else              c = 2;
    if (!seen[a]) distinct++;
    seen[a] = 1'b1;
    if (ri >= 0) real_q.delete(ri);
    else begin
      n_in_set = 0;
      last = -1;
      foreach (real_q[i]) if (real_q[i] % SETS == a % SETS) begin
        n_in_set++;
        last = i;
      end
      if (n_in_set == WAYS) real_q.delete(last);
    end
    real_q.push_front(a);
    if (si >= 0) shad_q.delete(si);
    else if (shad_q.size() == CAP) void'(shad_q.pop_back());
    shad_q.push_front(a);
    if (exp_cnt[c] < CMAX) exp_cnt[c]++;
    return c;
  endfunction

  task automatic chk(string req, string what, int got, int exp);
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s %s got %0d expected %0d", req, what, got, exp);
    end
  endtask

  // one clock: drive after negedge, compare at the next negedge
  task automatic step(bit v, int a, bit clr, string tag);
    bit ev;
    int ec;
    string rq;
    clear_i     = clr;
    req_valid_i = v;
    req_addr_i  = ADDR_W'(a);
    ev = v && !clr;
    ec = 0;
    if (clr) model_clear();
    else if (v) ec = model_access(a);
    @(negedge clk_i);
    n_vec++;
    rq = (tag != "") ? tag : (clr ? "R9" : "R1");
    chk(rq, "cls_valid", int'(cls_valid_o), int'(ev));
    if (ev) chk((tag != "") ? tag : cls_req(ec), "cls", int'(cls_o), ec);
    rq = clr ? "R9" : "R7";
    chk(exp_cnt[0] == CMAX ? "R8" : rq, "cnt_hit", int'(cnt_hit_o), exp_cnt[0]);
    chk(exp_cnt[1] == CMAX ? "R8" : rq, "cnt_comp", int'(cnt_comp_o), exp_cnt[1]);
    chk(exp_cnt[2] == CMAX ? "R8" : rq, "cnt_cap", int'(cnt_cap_o), exp_cnt[2]);
    chk(exp_cnt[3] == CMAX ? "R8" : rq, "cnt_conf", int'(cnt_conf_o), exp_cnt[3]);
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      n_bad++;
      $display("FAIL R1 watchdog expired got 0 expected 1");
      summary();
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr;
    model_clear();
    repeat (3) @(negedge clk_i);
    // R11: reset state
    n_vec++;
    chk("R11", "cls_valid", int'(cls_valid_o), 0);
    chk("R11", "cnt_hit", int'(cnt_hit_o), 0);
    chk("R11", "cnt_comp", int'(cnt_comp_o), 0);
    chk("R11", "cnt_cap", int'(cnt_cap_o), 0);
    chk("R11", "cnt_conf", int'(cnt_conf_o), 0);
    rst_ni = 1'b1;
    step(0, 0, 0, "R1");

    // R2/R3: first touches in set 0, then a hit
    step(1, 0, 0, "R2");
    step(1, 4, 0, "R2");
    step(1, 8, 0, "R2");
    step(1, 12, 0, "R2");
    step(1, 0, 0, "R3");
    step(0, 0, 0, "R1");
    // R4: fifth block in set 0 evicts 4; shadow still holds it
    step(1, 16, 0, "R2");
    step(1, 4, 0, "R4");

    // R6: hit refreshes LRU order in set 1
    step(0, 0, 1, "R9");
    step(1, 1, 0, "R2");
    step(1, 5, 0, "R2");
    step(1, 9, 0, "R2");
    step(1, 13, 0, "R2");
    step(1, 1, 0, "R6");
    step(1, 17, 0, "R2");
    step(1, 1, 0, "R6");
    step(1, 5, 0, "R6");

    // R5: working set of 20 overflows the 16-block shadow
    step(0, 0, 1, "R9");
    for (int i = 0; i < 20; i++) step(1, i, 0, "R2");
    step(1, 0, 0, "R5");

    // R8: drive the hit counter past saturation
    for (int i = 0; i < 20; i++) step(1, 19, 0, "R8");

    // R9: clear with a simultaneous request, then a seen block is new again
    step(1, 19, 1, "R9");
    step(1, 19, 0, "R9");

    // R10: distinct first touches counted exactly
    step(0, 0, 1, "R9");
    for (int i = 0; i < 30; i++) step(1, (i * 7) % 10 + 40, 0, "");
    n_vec++;
    chk("R10", "cnt_comp vs distinct", int'(cnt_comp_o), distinct);

    // mixed traffic
    step(0, 0, 1, "R9");
    lfsr = 16'hACE1;
    for (int i = 0; i < 600; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(lfsr[7:6] != 2'b00, int'(lfsr[5:0]), 0, "");
    end
    step(0, 0, 0, "R1");

    done = 1'b1;
    summary();
    $finish;
  end
endmodule